// File: doc/BRIEF.md
# Cycle-Steal Display Memory Arbiter

This block decides, on every internal clock, who may use a single-port display memory: the host processor or the display refresh path. Internal time is grouped into basic cycles of two clocks. The first clock of each pair is the host slot and the second is the refresh slot. A scan line is made of a fixed number of basic cycles. The first part of the line is the active display term, when refresh data must be fetched. The rest is the blanking term, when no fetch is needed.

A host memory access is a memory chip select that overlaps a read or write strobe. When such an access arrives while cycle stealing is enabled, the block pulls the wait line low at once. The request crosses into the internal clock domain through a synchronizer and is served in the next host slot. The grant returns as a toggle that is synchronized back to the host clock. The wait line is released on a host clock rising edge.

Cycle stealing is enabled during the active term, and also during a guard window made of the last `guard_w` basic cycles of blanking. Outside that window, host accesses are served with no wait at all. The window indication is brought out so that its timing can be observed.

Top module: `cs_arbiter`

## Requirements
- R1: A line lasts ACTIVE_CYC + BLANK_CYC basic cycles of two clocks each. `disp_active` is high for the first ACTIVE_CYC basic cycles. During that time `fetch_en` pulses for one clock in every basic cycle, never on two clocks in a row, which gives ACTIVE_CYC pulses per line.
- R2: `fetch_en` stays low whenever `disp_active` is low.
- R3: While cycle stealing is enabled, a host memory access drives `wait_n` low combinationally, with no clock edge needed. A host memory access is `mem_cs_n` low together with `rd_n` or `wr_n` low.
- R4: Each host memory access produces exactly one `host_en` pulse. `wait_n` returns high only after that pulse, on a rising edge of `host_clk`.
- R5: Strobes with `mem_cs_n` high (register accesses) never lower `wait_n` and produce no `host_en`.
- R6: An access made during blanking outside the guard window keeps `wait_n` high throughout, and is still served by one `host_en` pulse.
- R7: `steal_win` is high while `disp_active` is high. It also rises exactly `guard_w` basic cycles (2·`guard_w` clocks) before `disp_active` rises. With `guard_w` = 0, it equals `disp_active`.
- R8: `host_en` and `fetch_en` are never high in the same clock. When a request meets a refresh slot, the refresh slot wins.
- R9: Once a host request is pending in the internal domain, it is served within two clocks. During active display, a stolen access releases `wait_n` within 12 host clocks of the strobe.
- R10: While reset is held, `wait_n` is high, `host_en` and `fetch_en` are low, and `disp_active` and `steal_win` are high, because the line starts in its active term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal divided oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| host_clk | input | 1 | Host bus clock |
| mem_cs_n | input | 1 | Host display memory select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| guard_w | input | GW | Guard window width in basic cycles |
| wait_n | output | 1 | Host wait, active low |
| host_en | output | 1 | Memory port used by the host this clock |
| fetch_en | output | 1 | Memory port used by refresh this clock |
| steal_win | output | 1 | Cycle-steal enable window |
| disp_active | output | 1 | Active display term of the line |

## Verification
The bench uses a short line of 16 active and 12 blanking basic cycles, a 4-bit guard field, and a host clock of 14 ns against an internal clock of 10 ns. The short line makes the fetch count per line, the window edges for guard widths of 0, 3 and 5, and the three access regions (active, guard, open blanking) all reachable within a few hundred clocks. The unrelated clock periods make the synchronizer delays matter, so the release bound on the wait line is checked under a realistic phase relation.

// File: rtl/cs_arbiter.sv
module cs_arbiter #(
  parameter int ACTIVE_CYC = 80,
  parameter int BLANK_CYC  = 16,
  parameter int GW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_clk,
  input  logic          mem_cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [GW-1:0] guard_w,
  output logic          wait_n,
  output logic          host_en,
  output logic          fetch_en,
  output logic          steal_win,
  output logic          disp_active
);
  localparam int LINE = ACTIVE_CYC + BLANK_CYC;
  localparam int CW   = $clog2(LINE);

  // line timing: slot 0 = host, slot 1 = refresh
  logic          slot;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot <= 1'b0;
      bcnt <= '0;
    end else begin
      slot <= ~slot;
      if (slot) bcnt <= (int'(bcnt) == LINE - 1) ? '0 : bcnt + CW'(1);
    end

  assign disp_active = int'(bcnt) < ACTIVE_CYC;
  assign steal_win   = disp_active | ((int'(bcnt) + int'(guard_w)) >= LINE);
  assign fetch_en    = slot & disp_active;

  // host request, combinational from the bus
  logic req_raw;
  assign req_raw = ~mem_cs_n & (~rd_n | ~wr_n);

  // internal domain: synchronize, detect, hold until a free slot
  logic [2:0] req_s;
  logic       pend;
  logic       ack_t;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_s <= '0;
      pend  <= 1'b0;
      ack_t <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_raw};
      pend  <= (pend & fetch_en) | (req_s[1] & ~req_s[2]);
      if (host_en) ack_t <= ~ack_t;
    end

  assign host_en = pend & ~fetch_en;

  // host domain: window sync, grant sync, wait generation
  logic [1:0] steal_h;
  logic [2:0] ack_h;
  logic       done;
  logic       wlat;
  logic       ack_edge;

  assign ack_edge = ack_h[2] ^ ack_h[1];

  always_ff @(posedge host_clk or negedge rst_n)
    if (!rst_n) begin
      steal_h <= '0;
      ack_h   <= '0;
      done    <= 1'b0;
      wlat    <= 1'b0;
    end else begin
      steal_h <= {steal_h[0], steal_win};
      ack_h   <= {ack_h[1:0], ack_t};
      done    <= req_raw & (done | ack_edge);
      wlat    <= req_raw & ~done & ~ack_edge & (wlat | steal_h[1]);
    end

  assign wait_n = ~(req_raw & ~done & (wlat | steal_h[1]));

  // R8: refresh and host never share a clock
  a_r8_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && fetch_en));

  // R2: no refresh outside the active term
  a_r2_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_active |-> !fetch_en);

  // R1: refresh slots never back to back
  a_r1_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> !fetch_en);

  // R9: a pending request never waits past two clocks
  a_r9_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |=> !pend);

  // R7: the window covers the whole active term
  a_r7_covers_active: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> steal_win);

  // R5: no memory select, no wait
  a_r5_reg_no_wait: assert property (@(posedge host_clk) disable iff (!rst_n)
    mem_cs_n |-> wait_n);

  // R4: release only follows a grant seen in the host domain
  a_r4_release_after_grant: assert property (@(posedge host_clk) disable iff (!rst_n)
    (req_raw && !wait_n) |=> (!wait_n || !req_raw || done));
endmodule

// File: tb/tb_cs_arbiter.sv
module tb_cs_arbiter;
  localparam int CLK_P  = 10;
  localparam int HCLK_P = 14;
  localparam int ACT    = 16;
  localparam int BLK    = 12;
  localparam int GWB    = 4;
  localparam int LINE   = ACT + BLK;

  logic clk = 0, host_clk = 0, rst_n = 0;
  logic mem_cs_n = 1, rd_n = 1, wr_n = 1;
  logic [GWB-1:0] guard_w = 4'd3;
  logic wait_n, host_en, fetch_en, steal_win, disp_active;

  int checks = 0, errors = 0;
  int hcnt = 0, coll = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always #(HCLK_P/2) host_clk = ~host_clk;

  cs_arbiter #(.ACTIVE_CYC(ACT), .BLANK_CYC(BLK), .GW(GWB)) dut (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .mem_cs_n(mem_cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .guard_w(guard_w), .wait_n(wait_n),
    .host_en(host_en), .fetch_en(fetch_en), .steal_win(steal_win),
    .disp_active(disp_active));

  always @(negedge clk) begin
    if (host_en) hcnt++;
    if (host_en && fetch_en) coll++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_active_start();
    for (int i = 0; i < 200 && disp_active; i++) @(negedge clk);
    for (int i = 0; i < 200 && !disp_active; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(wait_n == 1, "R10 wait_n", wait_n, 1);
    chk(host_en == 0 && fetch_en == 0, "R10 enables", host_en + fetch_en, 0);
    chk(disp_active == 1 && steal_win == 1, "R10 line start", disp_active + steal_win, 2);
  endtask

  task automatic t_line_fetch();
    int fa = 0, fb = 0, dbl = 0;
    bit prev = 0;
    wait_active_start();
    for (int i = 0; i < 2*LINE; i++) begin
      if (fetch_en && disp_active) fa++;
      if (fetch_en && !disp_active) fb++;
      if (fetch_en && prev) dbl++;
      prev = fetch_en;
      @(negedge clk);
    end
    chk(fa == ACT, "R1 fetches per line", fa, ACT);
    chk(dbl == 0, "R1 back-to-back fetch", dbl, 0);
    chk(fb == 0, "R2 fetch in blanking", fb, 0);
  endtask

  task automatic t_guard_zero();
    int mis = 0;
    guard_w = 4'd0;
    wait_active_start();
    for (int i = 0; i < 2*LINE; i++) begin
      if (steal_win != disp_active) mis++;
      @(negedge clk);
    end
    chk(mis == 0, "R7 zero guard", mis, 0);
  endtask

  task automatic t_guard_width(input int gw);
    int n = 0;
    guard_w = GWB'(gw);
    wait_active_start();
    for (int i = 0; i < 200 && !(steal_win && !disp_active); i++) @(negedge clk);
    for (int i = 0; i < 200 && !disp_active; i++) begin
      n++;
      @(negedge clk);
    end
    chk(n == 2*gw, "R7 guard lead clocks", n, 2*gw);
  endtask

  task automatic t_stolen(input bit is_wr, input string tag);
    int h0, n = 0;
    wait_active_start();
    repeat (4) @(negedge host_clk);
    h0 = hcnt;
    mem_cs_n = 0;
    if (is_wr) wr_n = 0; else rd_n = 0;
    #1;
    chk(wait_n == 0, {tag, " R3 wait asserted"}, wait_n, 0);
    for (int i = 0; i < 30; i++) begin
      @(posedge host_clk); #1;
      if (wait_n) break;
      n++;
    end
    chk(wait_n == 1 && n >= 1 && n <= 12, {tag, " R9 release bound"}, n, 12);
    chk(hcnt - h0 == 1, {tag, " R4 one grant before release"}, hcnt - h0, 1);
    @(negedge host_clk);
    mem_cs_n = 1; rd_n = 1; wr_n = 1;
    repeat (6) @(negedge host_clk);
    chk(hcnt - h0 == 1, {tag, " R4 single grant"}, hcnt - h0, 1);
  endtask

  task automatic t_open_blank();
    int h0, hi = 0;
    for (int i = 0; i < 200 && !steal_win; i++) @(negedge clk);
    for (int i = 0; i < 200 && steal_win; i++) @(negedge clk);
    repeat (3) @(negedge host_clk);
    h0 = hcnt;
    mem_cs_n = 0; rd_n = 0;
    for (int i = 0; i < 4; i++) begin
      #1; if (wait_n) hi++;
      @(negedge host_clk);
    end
    mem_cs_n = 1; rd_n = 1;
    chk(hi == 4, "R6 no wait in open blanking", hi, 4);
    repeat (10) @(negedge clk);
    chk(hcnt - h0 == 1, "R6 access served", hcnt - h0, 1);
  endtask

  task automatic t_guard_access();
    int h0, n = 0;
    for (int i = 0; i < 200 && steal_win; i++) @(negedge clk);
    for (int i = 0; i < 200 && !steal_win; i++) @(negedge clk);
    repeat (3) @(negedge host_clk);
    h0 = hcnt;
    mem_cs_n = 0; wr_n = 0;
    #1;
    chk(wait_n == 0, "R3 wait in guard window", wait_n, 0);
    for (int i = 0; i < 30; i++) begin
      @(posedge host_clk); #1;
      if (wait_n) break;
      n++;
    end
    chk(wait_n == 1 && hcnt - h0 == 1, "R4 guard access released", hcnt - h0, 1);
    @(negedge host_clk);
    mem_cs_n = 1; wr_n = 1;
    repeat (6) @(negedge host_clk);
  endtask

  task automatic t_reg_access();
    int h0, hi = 0;
    wait_active_start();
    repeat (2) @(negedge host_clk);
    h0 = hcnt;
    rd_n = 0;
    for (int i = 0; i < 5; i++) begin
      #1; if (wait_n) hi++;
      @(negedge host_clk);
    end
    rd_n = 1;
    wr_n = 0;
    for (int i = 0; i < 5; i++) begin
      #1; if (wait_n) hi++;
      @(negedge host_clk);
    end
    wr_n = 1;
    repeat (6) @(negedge clk);
    chk(hi == 10, "R5 register access no wait", hi, 10);
    chk(hcnt == h0, "R5 register access no grant", hcnt - h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_line_fetch();
    t_guard_zero();
    t_guard_width(3);
    t_guard_width(5);
    guard_w = 4'd3;
    t_stolen(0, "read");
    t_stolen(1, "write");
    t_open_blank();
    t_guard_access();
    t_reg_access();
    chk(coll == 0, "R8 host and fetch collide", coll, 0);
    summary();
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end
endmodule